// File: doc/BRIEF.md
# GPIO Port Controller with Atomic Bit Operations

This block is a general-purpose I/O port of up to 32 pins, reached through a simple memory-mapped register bus. A data-output register holds the value presented to the pads. Software can write that register whole. It can also change selected bits without a read-modify-write, through three write-only addresses. One sets bits, one clears bits and one inverts bits. Each pin's level is brought in through a synchronizer, and the result can be read back from a data-input register.

The direction of each pin comes from the pad control cells as two per-pin enables, one for the input buffer and one for the output driver. The port follows them. A pin drives only while its output enable is high. A pin is captured only while its input enable is high. With both enables high the pin is bidirectional, and the input register then shows the level actually present on the pad.

Bus accesses take one cycle. Read data is registered and appears on the cycle after the read strobe. It holds until the next read.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, the data-output register is zero, every bit of `pin_drv_val` is 0, the synchronizer stages are zero and `bus_rdata` is zero.
- R2: A write to byte offset 0x00 loads all data-output bits from `bus_wdata`, and a read of offset 0x00 returns them.
- R3: A write to offset 0x04 sets every data-output bit whose `bus_wdata` bit is 1.
- R4: A write to offset 0x08 clears every data-output bit whose `bus_wdata` bit is 1.
- R5: A write to offset 0x0C inverts every data-output bit whose `bus_wdata` bit is 1.
- R6: Bits written as 0 to offsets 0x04, 0x08 or 0x0C leave the data-output register unchanged, and reads of those three offsets return zero.
- R7: `pin_drv_en[i]` equals `pad_oe[i]`. `pin_drv_val[i]` equals data-output bit i while `pad_oe[i]` is 1, and 0 otherwise.
- R8: A read of offset 0x10 returns the pin levels after a two-flop synchronizer. Any bit whose `pad_ie` is 0 reads 0.
- R9: With both `pad_oe[i]` and `pad_ie[i]` set, bit i of the input register reflects the actual level on the pad.
- R10: Writes to offset 0x10 or to any unmapped offset change no register. Reads of unmapped offsets return zero.
- R11: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | NUM_PINS | Write data |
| bus_rdata | output | NUM_PINS | Registered read data |
| pad_oe | input | NUM_PINS | Per-pin output-driver enable from the pad control cells |
| pad_ie | input | NUM_PINS | Per-pin input-buffer enable from the pad control cells |
| pin_in | input | NUM_PINS | Level present on each pad |
| pin_drv_en | output | NUM_PINS | Per-pin driver enable toward the pad |
| pin_drv_val | output | NUM_PINS | Per-pin value driven toward the pad |

## Verification
The bench builds the port with its defaults: 32 pins, a 5-bit byte address and two synchronizer stages. The full 32-bit width covers several cases that a narrower build would not show. Set, clear and toggle masks cover both halves of the word, including the top bit. The input-enable mask can split the word into interleaved bytes. A bidirectional case can mix driven bits and externally held bits in one read. The 5-bit address reaches the input register at 0x10 and also an unmapped offset just past it, so the decode of writes that must be ignored is exercised.

// File: rtl/gpio_port_pkg.sv
// Shared definitions for the GPIO port: register byte offsets and the
// decoded bus operation passed from the address decoder to the datapath.
package gpio_port_pkg;

    localparam int unsigned OFS_DOUT = 32'h00;
    localparam int unsigned OFS_SET  = 32'h04;
    localparam int unsigned OFS_CLR  = 32'h08;
    localparam int unsigned OFS_TOG  = 32'h0C;
    localparam int unsigned OFS_DIN  = 32'h10;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_DOUT,
        ACC_SET,
        ACC_CLR,
        ACC_TOG,
        ACC_DIN
    } acc_kind_e;

    typedef struct packed {
        logic      act;
        logic      wr;
        acc_kind_e kind;
    } bus_op_t;

endpackage

// File: rtl/gpio_bus_decode.sv
// Address decoder for the GPIO port.
// Turns a one-cycle bus strobe into a decoded operation.
// Assumes byte offsets that are word aligned. Any other offset decodes to
// ACC_NONE, so it can change nothing and reads back zero.
module gpio_bus_decode
    import gpio_port_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output bus_op_t           op
);

    // Map the offset to a register kind and qualify it with the strobe.
    always_comb begin
        op.act  = bus_sel;
        op.wr   = bus_wr;
        op.kind = ACC_NONE;
        if (bus_addr == ADDR_W'(OFS_DOUT))     op.kind = ACC_DOUT;
        else if (bus_addr == ADDR_W'(OFS_SET)) op.kind = ACC_SET;
        else if (bus_addr == ADDR_W'(OFS_CLR)) op.kind = ACC_CLR;
        else if (bus_addr == ADDR_W'(OFS_TOG)) op.kind = ACC_TOG;
        else if (bus_addr == ADDR_W'(OFS_DIN)) op.kind = ACC_DIN;
    end

endmodule

// File: rtl/gpio_out_reg.sv
// Data-output register of the GPIO port.
// Supports a whole-word load and masked set, clear and invert operations.
// Assumes at most one operation per cycle, which a single bus guarantees.
module gpio_out_reg
    import gpio_port_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  bus_op_t             op,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] dout
);

    logic                wr_hit;
    logic [NUM_PINS-1:0] dout_nxt;

    assign wr_hit = op.act && op.wr;

    // Next value of the register for each kind of write.
    always_comb begin
        dout_nxt = dout;
        if (wr_hit) begin
            case (op.kind)
                ACC_DOUT: dout_nxt = wdata;
                ACC_SET:  dout_nxt = dout | wdata;
                ACC_CLR:  dout_nxt = dout & ~wdata;
                ACC_TOG:  dout_nxt = dout ^ wdata;
                default:  dout_nxt = dout;
            endcase
        end
    end

    // Hold the output register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) dout <= '0;
        else        dout <= dout_nxt;
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Input capture of the GPIO port: one synchronizer chain per pin.
// Each pin level is gated by its input enable before the first stage, so a
// disabled pin reads 0 once the chain has flushed.
// Assumes SYNC_STAGES >= 2.
module gpio_in_sync #(
    parameter int unsigned NUM_PINS    = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] pad_ie,
    output logic [NUM_PINS-1:0] din
);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic [SYNC_STAGES-1:0] chain;

        // Shift the gated pin level through the synchronizer.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-2:0], pin_in[g] & pad_ie[g]};
        end

        assign din[g] = chain[SYNC_STAGES-1];
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
// GPIO port top.
// Ties together the address decoder, the data-output register, the
// per-pin input synchronizers and the registered read mux.
// The pad enables arrive from the pad control cells. The port drives a pin
// only while its output enable is set.
// Assumes NUM_PINS <= 32 and byte offsets on a word-aligned bus.
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 32,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pad_oe,
    input  logic [NUM_PINS-1:0] pad_ie,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_drv_en,
    output logic [NUM_PINS-1:0] pin_drv_val
);

    bus_op_t             op;
    logic [NUM_PINS-1:0] dout;
    logic [NUM_PINS-1:0] din;
    logic [NUM_PINS-1:0] rd_nxt;

    gpio_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .op       (op)
    );

    gpio_out_reg #(.NUM_PINS(NUM_PINS)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .wdata (bus_wdata),
        .dout  (dout)
    );

    gpio_in_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_in (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .pad_ie (pad_ie),
        .din    (din)
    );

    // Select read data. The write-only and unmapped offsets return zero.
    always_comb begin
        case (op.kind)
            ACC_DOUT: rd_nxt = dout;
            ACC_DIN:  rd_nxt = din;
            default:  rd_nxt = '0;
        endcase
    end

    // Register read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                bus_rdata <= '0;
        else if (op.act && !op.wr) bus_rdata <= rd_nxt;
    end

    // Drive only the pins whose output enable is set.
    assign pin_drv_en  = pad_oe;
    assign pin_drv_val = dout & pad_oe;

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
// Checker for the GPIO port. It watches the bus and the pad side of the
// top module and checks the atomic bit operations against the driven pins.
// It is attached to the top module by the bind at the end of this file.
module gpio_port_ctrl_chk
    import gpio_port_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned ADDR_W   = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NUM_PINS-1:0] bus_wdata,
    input logic [NUM_PINS-1:0] bus_rdata,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pin_drv_val
);

    logic wr_set, wr_clr, wr_tog, any_wr, rd_wo;

    assign wr_set = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_SET));
    assign wr_clr = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CLR));
    assign wr_tog = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_TOG));
    assign any_wr = bus_sel && bus_wr;
    assign rd_wo  = bus_sel && !bus_wr &&
                    ((bus_addr == ADDR_W'(OFS_SET)) || (bus_addr == ADDR_W'(OFS_CLR)) ||
                     (bus_addr == ADDR_W'(OFS_TOG)));

    // R3
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((($past(bus_wdata) & pad_oe) & ~pin_drv_val) == '0));

    // R4
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> (($past(bus_wdata) & pin_drv_val) == '0));

    // R5
    tog_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tog |=> (((pin_drv_val ^ $past(pin_drv_val)) & pad_oe & $past(pad_oe)) ==
                    ($past(bus_wdata) & pad_oe & $past(pad_oe))));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_wr |=> (((pin_drv_val ^ $past(pin_drv_val)) & pad_oe & $past(pad_oe)) == '0));

    // R6
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_wo |=> (bus_rdata == '0));

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pad_oe      (pad_oe),
    .pin_drv_val (pin_drv_val)
);

// File: tb/gpio_port_ctrl_test.sv
`timescale 1ns/1ps
// Scoreboard bench for the GPIO port: the read driver queues expected words,
// and a monitor compares them with bus_rdata one cycle after each read.
module gpio_port_ctrl_test;

    localparam int NP = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [NP-1:0] bus_wdata = '0;
    logic [NP-1:0] bus_rdata;
    logic [NP-1:0] pad_oe = '0;
    logic [NP-1:0] pad_ie = '0;
    logic [NP-1:0] ext_lvl = '0;
    logic [NP-1:0] pin_in;
    logic [NP-1:0] pin_drv_en;
    logic [NP-1:0] pin_drv_val;

    int total = 0;
    int bad = 0;
    logic [NP-1:0] mdl_dout = '0;
    logic rd_issue = 1'b0;
    logic rd_flag = 1'b0;
    logic [NP-1:0] exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    // Pad model: a driven pin shows the port value, any other pin the outside level.
    assign pin_in = (pin_drv_en & pin_drv_val) | (~pin_drv_en & ext_lvl);

    gpio_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_oe(pad_oe), .pad_ie(pad_ie), .pin_in(pin_in),
        .pin_drv_en(pin_drv_en), .pin_drv_val(pin_drv_val)
    );

    task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        case (a)
            5'h00: mdl_dout = d;
            5'h04: mdl_dout = mdl_dout | d;
            5'h08: mdl_dout = mdl_dout & ~d;
            5'h0C: mdl_dout = mdl_dout ^ d;
            default: ;
        endcase
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [NP-1:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; rd_issue = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; rd_issue = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Mark the cycle whose edge registered a read.
    always @(posedge clk) rd_flag <= rd_issue;

    // Monitor: pop one expected word per completed read and compare.
    always @(negedge clk) begin
        if (rd_flag && exp_q.size() > 0) begin
            logic [NP-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, bus_rdata, e);
        end
    end

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state
        check("R1 drv_val", pin_drv_val, '0);
        check("R1 rdata", bus_rdata, '0);
        rd(5'h00, 32'h0, "R1 dout reset");
        pad_ie = '1;
        idle(3);
        rd(5'h10, 32'h0, "R1 din reset");

        pad_oe = '1;
        wr(5'h00, 32'hA5A5_0F0F);
        rd(5'h00, 32'hA5A5_0F0F, "R2 whole write");
        check("R7 drv_val full oe", pin_drv_val, 32'hA5A5_0F0F);
        check("R7 drv_en", pin_drv_en, '1);

        wr(5'h04, 32'h8000_F0F0);
        rd(5'h00, 32'hA5A5_FFFF, "R3 set");
        wr(5'h08, 32'hA000_000F);
        rd(5'h00, 32'h05A5_FFF0, "R4 clear");
        wr(5'h0C, 32'hFFFF_0001);
        rd(5'h00, 32'hFA5A_FFF1, "R5 toggle");

        wr(5'h04, 32'h0); wr(5'h08, 32'h0); wr(5'h0C, 32'h0);
        rd(5'h00, 32'hFA5A_FFF1, "R6 zero masks");
        rd(5'h04, 32'h0, "R6 set reads zero");
        rd(5'h08, 32'h0, "R6 clear reads zero");
        rd(5'h0C, 32'h0, "R6 toggle reads zero");

        pad_oe = 32'h0000_FFFF;
        @(negedge clk);
        check("R7 drv_val partial oe", pin_drv_val, mdl_dout & 32'h0000_FFFF);
        check("R7 drv_en partial", pin_drv_en, 32'h0000_FFFF);

        pad_oe = '0; pad_ie = '1; ext_lvl = 32'h1234_5678;
        idle(3);
        rd(5'h10, 32'h1234_5678, "R8 capture");
        pad_ie = 32'h00FF_00FF;
        idle(3);
        rd(5'h10, 32'h0034_0078, "R8 ie gating");

        pad_oe = 32'hFFFF_0000; pad_ie = '1; ext_lvl = 32'h0000_ABCD;
        idle(3);
        rd(5'h10, (mdl_dout & 32'hFFFF_0000) | 32'h0000_ABCD, "R9 bidirectional");

        wr(5'h10, 32'hDEAD_BEEF);
        wr(5'h14, 32'hDEAD_BEEF);
        rd(5'h00, mdl_dout, "R10 ignored writes");
        rd(5'h14, 32'h0, "R10 unmapped read");

        rd(5'h00, mdl_dout, "R11 read");
        idle(4);
        check("R11 rdata holds", bus_rdata, mdl_dout);

        idle(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule